// File: doc/BRIEF.md
# Triple Watchdog Timer Peripheral

The block holds three independent watchdog channels behind a small register bus. Each channel owns a 16-bit down-counter that steps once per tenth of a second and a 16-bit reload value. A shared prescaler divides the system clock into a single-cycle 10 Hz tick. Writing a channel's reload value loads the counter and starts it. Reading the counter returns its value and, on a running channel, reloads it. That read is how software services the watchdog.

When a running counter reaches zero, the channel stops and flags expiry. It then raises its own action output, and the action differs by channel. Channel 0 drives an interrupt, channel 1 drives a processor-only reset request, and channel 2 drives a whole-board reset request. A shared mask register can suppress each action. A masked channel still counts down and still flags expiry. Halfword registers appear byte-swapped on the bus.

Top module: `wdt_trio`

## Requirements
- R1: After reset every channel is stopped with counter = 1, reload = 1, status = 0x00. The mask reads 0x00, and all three action outputs are low.
- R2: A halfword write to a channel's reload register (channel base + 4) stores the value and copies it into the counter. It sets running, clears expired, and drops that channel's action output, all from the next cycle.
- R3: A running counter decrements by one on each prescaler tick. The tick occurs once every CLK_HZ/TICK_HZ clocks, at clock edges n with n mod DIV = 0, counting from the first edge after reset release.
- R4: A running channel whose counter is 0 or 1 when a tick arrives expires. On expiry the counter becomes 0, running clears and expired sets. So a reload value of L expires on the L-th tick after the write, and a reload value of 0 behaves like 1.
- R5: A halfword read of the counter (channel base + 0) returns the counter value from before the access. On a running channel it also reloads the counter from the reload register. The reload takes priority over a tick in the same cycle.
- R6: A counter read on a stopped or expired channel returns the value and changes nothing. It does not start or restart the channel.
- R7: A read of the reload register returns it and does not change the countdown.
- R8: A byte read at channel base + 8 returns the status byte. Bit 0 is running, bit 1 is expired, and bits 7..2 are 0.
- R9: An unmasked expiry raises the channel's action output: channel 0 drives irq_o, channel 1 drives cpu_rst_o, and channel 2 drives sys_rst_o. The output stays high until the next reload write to that channel.
- R10: The mask is a byte register at address 48. Bit i set to 1 suppresses channel i's action, while the counter still runs and the expired bit still sets. Bits 7..3 read 0, and a byte read at address 52 returns 0.
- R11: Halfword data is byte-swapped on the bus. Data bits 7..0 carry register bits 15..8, and data bits 15..8 carry register bits 7..0. This applies to both reads and writes.
- R12: Counter and reload respond only to halfword accesses, and status and mask respond only to byte accesses. An access of the other width has no effect and reads 0.
- R13: Read data is registered and appears on bus_rdata_o in the cycle after the read is accepted. It holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Access strobe, one access per cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_half_i | input | 1 | 1 = halfword access, 0 = byte access |
| bus_addr_i | input | 6 | Byte address |
| bus_wdata_i | input | 16 | Write data (byte accesses use bits 7..0) |
| bus_rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Channel 0 expiry interrupt (level) |
| cpu_rst_o | output | 1 | Channel 1 processor reset request (level) |
| sys_rst_o | output | 1 | Channel 2 board reset request (level) |

## Verification
Every access, and every effect it has, lands at the clock edge that accepts it. Read data is due one edge later, and action outputs follow the expiring tick edge with no added delay. The bench counts edges from reset release. It predicts the expiry edge as the first tick after the reload write plus DIV clocks for each further count. It then samples the action outputs at the negative edge just before and just after that edge. A counter read is aimed at an edge one cycle after a known tick, so that the value returned is fixed by arithmetic. The bench then moves its expected expiry edge to follow the reload.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  localparam int NUM_CH   = 3;
  localparam int CNT_W    = 16;
  localparam int ADDR_W   = 6;
  localparam logic [3:0] OFF_CNT  = 4'h0;
  localparam logic [3:0] OFF_LIM  = 4'h4;
  localparam logic [3:0] OFF_STAT = 4'h8;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 6'd48;
  localparam logic [ADDR_W-1:0] ADDR_AUX  = 6'd52;

  function automatic logic [15:0] swap16(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
`timescale 1ns/1ps
module wdt_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] div_q;

  assign tick_o = (div_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (tick_o) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/wdt_channel.sv
`timescale 1ns/1ps
module wdt_channel #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          kick_i,
  input  logic          mask_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] lim_o,
  output logic          run_o,
  output logic          exp_o,
  output logic          act_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= ONE;
      lim_o <= ONE;
      run_o <= 1'b0;
      exp_o <= 1'b0;
      act_o <= 1'b0;
    end else if (load_i) begin
      cnt_o <= load_val_i;
      lim_o <= load_val_i;
      run_o <= 1'b1;
      exp_o <= 1'b0;
      act_o <= 1'b0;
    end else if (run_o) begin
      if (kick_i) begin
        cnt_o <= lim_o;               // service beats a coincident tick
      end else if (tick_i) begin
        if (cnt_o <= ONE) begin
          cnt_o <= '0;
          run_o <= 1'b0;
          exp_o <= 1'b1;
          if (!mask_i) act_o <= 1'b1;
        end else begin
          cnt_o <= cnt_o - ONE;
        end
      end
    end
  end
endmodule

// File: rtl/wdt_trio.sv
`timescale 1ns/1ps
module wdt_trio
  import wdt_pkg::*;
#(
  parameter int CLK_HZ  = 50_000_000,
  parameter int TICK_HZ = 10
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_req_i,
  input  logic        bus_we_i,
  input  logic        bus_half_i,
  input  logic [5:0]  bus_addr_i,
  input  logic [15:0] bus_wdata_i,
  output logic [15:0] bus_rdata_o,
  output logic        irq_o,
  output logic        cpu_rst_o,
  output logic        sys_rst_o
);
  localparam int DIV = CLK_HZ / TICK_HZ;

  logic                          tick;
  logic [NUM_CH-1:0]             load, kick, run_q, exp_q, act_q;
  logic [NUM_CH-1:0][CNT_W-1:0]  cnt_q, lim_q;
  logic [NUM_CH-1:0]             mask_q;
  logic [15:0]                   rd_d;

  wire half_rd = bus_req_i & ~bus_we_i &  bus_half_i;
  wire half_wr = bus_req_i &  bus_we_i &  bus_half_i;
  wire byte_rd = bus_req_i & ~bus_we_i & ~bus_half_i;
  wire byte_wr = bus_req_i &  bus_we_i & ~bus_half_i;
  wire [1:0] ch_sel = bus_addr_i[5:4];
  wire [3:0] reg_off = bus_addr_i[3:0];

  wdt_prescaler #(.DIV(DIV)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign load[i] = half_wr & (ch_sel == 2'(i)) & (reg_off == OFF_LIM);
    assign kick[i] = half_rd & (ch_sel == 2'(i)) & (reg_off == OFF_CNT);

    wdt_channel #(.CW(CNT_W)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick),
      .load_i    (load[i]),
      .load_val_i(swap16(bus_wdata_i)),
      .kick_i    (kick[i]),
      .mask_i    (mask_q[i]),
      .cnt_o     (cnt_q[i]),
      .lim_o     (lim_q[i]),
      .run_o     (run_q[i]),
      .exp_o     (exp_q[i]),
      .act_o     (act_q[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                mask_q <= '0;
    else if (byte_wr && bus_addr_i == ADDR_MASK) mask_q <= bus_wdata_i[NUM_CH-1:0];
  end

  always_comb begin
    rd_d = '0;
    if (half_rd) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (ch_sel == 2'(i) && reg_off == OFF_CNT) rd_d = swap16(cnt_q[i]);
        if (ch_sel == 2'(i) && reg_off == OFF_LIM) rd_d = swap16(lim_q[i]);
      end
    end else if (byte_rd) begin
      for (int i = 0; i < NUM_CH; i++)
        if (ch_sel == 2'(i) && reg_off == OFF_STAT) rd_d = {14'b0, exp_q[i], run_q[i]};
      if (bus_addr_i == ADDR_MASK) rd_d = {{(16-NUM_CH){1'b0}}, mask_q};
      // ADDR_AUX reads as zero
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       bus_rdata_o <= '0;
    else if (bus_req_i && !bus_we_i)   bus_rdata_o <= rd_d;
  end

  assign irq_o     = act_q[0];
  assign cpu_rst_o = act_q[1];
  assign sys_rst_o = act_q[2];
endmodule

// File: rtl/wdt_trio_chk.sv
`timescale 1ns/1ps
module wdt_trio_chk #(
  parameter int NC = 3,
  parameter int CW = 16
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  tick,
  input logic [NC-1:0]         load,
  input logic [NC-1:0]         kick,
  input logic [NC-1:0]         run_q,
  input logic [NC-1:0]         exp_q,
  input logic [NC-1:0]         act_q,
  input logic [NC-1:0]         mask_q,
  input logic [NC-1:0][CW-1:0] cnt_q,
  input logic [NC-1:0][CW-1:0] lim_q,
  input logic                  irq_o
);
  for (genvar i = 0; i < NC; i++) begin : g_a
    assert_load_starts_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load[i] |=> run_q[i] && !exp_q[i] && !act_q[i]);

    assert_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_q[i] && tick && !load[i] && !kick[i] && cnt_q[i] > CW'(1)
      |=> cnt_q[i] == CW'($past(cnt_q[i]) - CW'(1)));

    assert_kick_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_q[i] && kick[i] && !load[i] |=> cnt_q[i] == $past(lim_q[i]));

    assert_stopped_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_q[i] && !load[i] |=> !run_q[i] && $stable(cnt_q[i]));

    assert_status_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(run_q[i] && exp_q[i]));

    assert_act_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(act_q[i]) |-> exp_q[i] && !$past(mask_q[i]));
  end

  assert_irq_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !load[0] |=> irq_o);
endmodule

bind wdt_trio wdt_trio_chk #(.NC(wdt_pkg::NUM_CH), .CW(wdt_pkg::CNT_W)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .tick  (tick),
  .load  (load),
  .kick  (kick),
  .run_q (run_q),
  .exp_q (exp_q),
  .act_q (act_q),
  .mask_q(mask_q),
  .cnt_q (cnt_q),
  .lim_q (lim_q),
  .irq_o (irq_o)
);

// File: tb/sim_wdt_trio.sv
`timescale 1ns/1ps
module sim_wdt_trio;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0, half = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq, cpu_rst, sys_rst;
  int          ecnt = 0;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  always @(posedge clk) if (rst_ni) ecnt <= ecnt + 1;

  wdt_trio #(.CLK_HZ(40), .TICK_HZ(10)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .bus_req_i(req), .bus_we_i(we),
    .bus_half_i(half), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq), .cpu_rst_o(cpu_rst), .sys_rst_o(sys_rst)
  );

  function automatic logic [15:0] sw(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction

  function automatic logic [15:0] acts();
    return {13'b0, sys_rst, cpu_rst, irq};
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // called at a negedge; access lands on the next posedge, returns at the following negedge
  task automatic op(input logic w, input logic h, input logic [5:0] a, input logic [15:0] d);
    req = 1'b1; we = w; half = h; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic wait_to(input int n);
    while (ecnt < n) @(negedge clk);
  endtask

  function automatic int next_tick(input int w);
    return (w / DIV + 1) * DIV;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int w, t1, t2, e, lv;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    chk("R1 actions", acts(), 16'h0);
    op(0, 0, 6'd8, 0);  chk("R1 status ch0", rdata, 16'h0000);
    op(0, 0, 6'd40, 0); chk("R1 R8 status ch2", rdata, 16'h0000);
    op(0, 1, 6'd20, 0); chk("R1 R7 R11 limit ch1", rdata, 16'h0100);
    op(0, 0, 6'd48, 0); chk("R1 R10 mask", rdata, 16'h0000);
    op(0, 0, 6'd52, 0); chk("R10 aux byte", rdata, 16'h0000);
    op(0, 1, 6'd0, 0);  chk("R1 R5 R13 counter ch0", rdata, 16'h0100);
    repeat (3 * DIV) @(negedge clk);
    chk("R6 stopped after read: actions", acts(), 16'h0);
    op(0, 0, 6'd8, 0);  chk("R6 stopped after read: status", rdata, 16'h0000);

    // R12 wrong-width accesses
    op(1, 0, 6'd4, 16'h0002);
    op(0, 0, 6'd8, 0);  chk("R12 byte write to limit ignored", rdata, 16'h0000);
    op(0, 1, 6'd4, 0);  chk("R12 limit unchanged", rdata, 16'h0100);
    op(0, 1, 6'd8, 0);  chk("R12 halfword status read", rdata, 16'h0000);
    op(0, 0, 6'd0, 0);  chk("R12 byte counter read", rdata, 16'h0000);
    op(1, 1, 6'd48, 16'h0707);
    op(0, 0, 6'd48, 0); chk("R12 halfword mask write ignored", rdata, 16'h0000);
    op(1, 0, 6'd48, 16'h00FF);
    op(0, 0, 6'd48, 0); chk("R10 mask upper bits zero", rdata, 16'h0007);
    op(1, 0, 6'd48, 16'h0000);
    op(0, 0, 6'd48, 0); chk("R10 mask cleared", rdata, 16'h0000);

    // sweep: channel x mask x reload value
    for (int ch = 0; ch < 3; ch++) begin
      for (int msk = 0; msk < 2; msk++) begin
        for (int k = 0; k < 5; k++) begin
          lv = (k == 4) ? 5 : k;
          op(1, 0, 6'd48, msk ? 16'(1 << ch) : 16'h0);
          op(1, 1, 6'(ch * 16 + 4), sw(16'(lv)));
          w  = ecnt;
          t1 = next_tick(w);
          e  = t1 + ((lv < 1) ? 0 : lv - 1) * DIV;
          chk("R2 actions after load", acts(), 16'h0);
          op(0, 0, 6'(ch * 16 + 8), 0);
          chk("R2 R8 running status", rdata, 16'h0001);
          if (ecnt < e - 1) begin
            wait_to(e - 1);
            chk("R3 R11 no action before expiry tick", acts(), 16'h0);
          end
          wait_to(e);
          chk(msk ? "R10 masked expiry silent" : "R4 R9 action on expiry",
              acts(), msk ? 16'h0 : 16'(1 << ch));
          op(0, 0, 6'(ch * 16 + 8), 0);
          chk("R4 R8 R10 expired status", rdata, 16'h0002);
          op(0, 1, 6'(ch * 16), 0);
          chk("R4 counter zero", rdata, 16'h0000);
          op(0, 0, 6'(ch * 16 + 8), 0);
          chk("R6 read of expired does not restart", rdata, 16'h0002);
          repeat (2 * DIV) @(negedge clk);
          chk("R9 action held", acts(), msk ? 16'h0 : 16'(1 << ch));
          op(1, 1, 6'(ch * 16 + 4), 16'hFFFF);
          chk("R2 load clears action", acts(), 16'h0);
          op(0, 0, 6'(ch * 16 + 8), 0);
          chk("R2 restarted status", rdata, 16'h0001);
        end
      end
    end
    op(1, 0, 6'd48, 16'h0000);

    // R5 service read on channel 1, reload 4
    op(1, 1, 6'd20, sw(16'd4));
    w  = ecnt;
    t1 = next_tick(w);
    wait_to(t1);
    op(0, 1, 6'd16, 0);
    chk("R5 R13 counter value before reload", rdata, sw(16'd3));
    t2 = t1 + DIV;
    e  = t2 + 3 * DIV;
    wait_to(t2);
    op(0, 1, 6'd20, 0);
    chk("R7 limit read", rdata, sw(16'd4));
    wait_to(t1 + 3 * DIV);
    chk("R5 original deadline passes quietly", acts(), 16'h0);
    wait_to(e - 1);
    chk("R5 R7 no action before new deadline", acts(), 16'h0);
    wait_to(e);
    chk("R5 R9 cpu reset at new deadline", acts(), 16'h0002);
    op(1, 1, 6'd20, 16'hFFFF);
    chk("R2 cpu reset cleared", acts(), 16'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule